// File: doc/BRIEF.md
# Disk Drive Status Word Generator

This block holds the error and status state of each drive attached to a disk controller and turns it into a 16-bit status word when software asks for a status check. Drive-side logic reports events as one-cycle pulses, one bit per drive: address error, end of cylinder, flagged, and data error. It also reports busy set and busy clear as pulses, and each drive's heads-unloaded condition as a level. The command issue path sends a per-drive status clear when a seek, recalibrate or check is started. The data-channel path sends an overrun pulse naming the busy drive.

A status read is a valid/ready request that carries the drive number. A read is taken on a clock edge where `rd_valid` and `rd_ready` are both high. The word is registered and appears on the next cycle with `st_valid`. It stays there unchanged until the edge where `st_ready` is high. `rd_ready` is high whenever the output register is empty or is being drained in the same cycle. A request made while the output is stalled is not taken, so it neither changes the word nor clears anything. The any-error summary bit and the drive identity bit are built when the word is formed and are not stored. Taking a read clears the error flags of that drive and keeps its busy flag.

Top module: `disk_status_word`

## Requirements
- R1: Status word bit positions: bit 5 end of cylinder, bit 4 address error, bit 3 flagged, bit 2 busy, bit 1 data error. Bits 15..8 are always zero. A set pulse on a drive is reported in the next word read from that drive.
- R2: Bit 0 is 1 exactly when any of bits 6, 5, 4, 3 or 1 is 1 in the returned word. Busy alone leaves bit 0 at 0.
- R3: While a drive's heads-unloaded level is high, its word is bit 6 (not ready) plus bit 0 and the identity bit only, whatever status is stored.
- R4: Bit 7 is 1 when drive 1 is read and 0 when drive 0 is read.
- R5: Taking a read clears the stored end-of-cylinder, address, flagged and data error flags of the drive read. Its busy flag and the other drive's state are kept.
- R6: A status clear pulse for a drive clears all of its stored status, busy included.
- R7: An overrun pulse sets the data error flag of the drive named by `ovr_drv` only.
- R8: When an error set pulse lands in the same cycle as the post-read clear of that drive, the set is kept. The word taken in that cycle does not show it, and the next read does.
- R9: A read is taken when `rd_valid` and `rd_ready` are both high, with `rd_ready = !st_valid || st_ready`. The word is presented with `st_valid` on the following cycle and held stable until `st_ready` is seen.
- R10: A busy set pulse sets the busy flag and a busy clear pulse clears it. If both arrive in the same cycle, the flag is set.
- R11: After reset, `st_valid` is 0, `rd_ready` is 1 and all stored status of both drives is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aer_set | input | NUM_DRV | Address error set pulse, per drive |
| eoc_set | input | NUM_DRV | End-of-cylinder set pulse, per drive |
| flg_set | input | NUM_DRV | Flagged set pulse, per drive |
| dte_set | input | NUM_DRV | Data error set pulse, per drive |
| busy_set | input | NUM_DRV | Busy set pulse, per drive |
| busy_clr | input | NUM_DRV | Busy clear pulse, per drive |
| stat_clr | input | NUM_DRV | Whole-status clear at command issue, per drive |
| ovr_pulse | input | 1 | Data-channel overrun event |
| ovr_drv | input | DRV_W | Drive charged with the overrun |
| unloaded | input | NUM_DRV | Heads-unloaded level, per drive |
| rd_valid | input | 1 | Status read request |
| rd_ready | output | 1 | Read request can be taken |
| rd_drv | input | DRV_W | Drive selected for the read |
| st_valid | output | 1 | Status word present |
| st_ready | input | 1 | Consumer takes the word |
| st_word | output | 16 | Assembled status word |

## Verification
Two functions can fall in the same cycle: an error set pulse and the clear that follows a taken read of the same drive. The bench raises `aer_set` for drive 0 on the same edge where a drive-0 read is taken. It expects the word from that read to lack the flag and the following read to show it with the summary bit. The busy set and busy clear pulses are also raised together, and the bench expects busy to remain set. A read request made while the output is stalled is judged by the word staying fixed and `rd_ready` staying low.

// File: rtl/dsw_pkg.sv
package dsw_pkg;
  localparam int WORD_W = 16;
  localparam int B_ANY  = 0;
  localparam int B_DTE  = 1;
  localparam int B_BUSY = 2;
  localparam int B_FLG  = 3;
  localparam int B_AER  = 4;
  localparam int B_EOC  = 5;
  localparam int B_NRDY = 6;
  localparam int B_DID  = 7;

  typedef struct packed {
    logic eoc;
    logic aer;
    logic flg;
    logic dte;
    logic busy;
  } drv_stat_t;

  typedef struct packed {
    logic eoc;
    logic aer;
    logic flg;
    logic dte;
  } err_ev_t;
endpackage

// File: rtl/dsw_drive_reg.sv
module dsw_drive_reg
  import dsw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  err_ev_t   ev_set,
  input  logic      busy_set,
  input  logic      busy_clr,
  input  logic      stat_clr,
  input  logic      rd_clr,
  output drv_stat_t stat_q
);
  drv_stat_t stat_d;

  always_comb begin
    stat_d = stat_q;
    if (stat_clr) stat_d = '0;
    if (rd_clr) begin
      stat_d.eoc = 1'b0;
      stat_d.aer = 1'b0;
      stat_d.flg = 1'b0;
      stat_d.dte = 1'b0;
    end
    if (busy_clr) stat_d.busy = 1'b0;
    // sets are applied last so they win over every clear
    stat_d.eoc  = stat_d.eoc | ev_set.eoc;
    stat_d.aer  = stat_d.aer | ev_set.aer;
    stat_d.flg  = stat_d.flg | ev_set.flg;
    stat_d.dte  = stat_d.dte | ev_set.dte;
    stat_d.busy = stat_d.busy | busy_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && ev_set.aer) |=> stat_q.aer);

  p_busy_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !stat_clr && !busy_set && !busy_clr) |=> $stable(stat_q.busy));

  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && ev_set == '0) |=> (!stat_q.eoc && !stat_q.aer && !stat_q.flg && !stat_q.dte));

  p_stat_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && ev_set == '0 && !busy_set) |=> (stat_q == '0));

  p_busy_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_set |=> stat_q.busy);
endmodule

// File: rtl/dsw_format.sv
module dsw_format
  import dsw_pkg::*;
(
  input  drv_stat_t         stat,
  input  logic              unloaded,
  input  logic              drv_id,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] base;

  always_comb begin
    base = '0;
    if (unloaded) begin
      base[B_NRDY] = 1'b1;
    end else begin
      base[B_EOC]  = stat.eoc;
      base[B_AER]  = stat.aer;
      base[B_FLG]  = stat.flg;
      base[B_BUSY] = stat.busy;
      base[B_DTE]  = stat.dte;
    end
    word        = base;
    word[B_ANY] = base[B_NRDY] | base[B_EOC] | base[B_AER] | base[B_FLG] | base[B_DTE];
    word[B_DID] = drv_id;
  end
endmodule

// File: rtl/disk_status_word.sv
module disk_status_word
  import dsw_pkg::*;
#(
  parameter  int NUM_DRV = 2,
  localparam int DRV_W   = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_DRV-1:0] aer_set,
  input  logic [NUM_DRV-1:0] eoc_set,
  input  logic [NUM_DRV-1:0] flg_set,
  input  logic [NUM_DRV-1:0] dte_set,
  input  logic [NUM_DRV-1:0] busy_set,
  input  logic [NUM_DRV-1:0] busy_clr,
  input  logic [NUM_DRV-1:0] stat_clr,
  input  logic               ovr_pulse,
  input  logic [DRV_W-1:0]   ovr_drv,
  input  logic [NUM_DRV-1:0] unloaded,
  input  logic               rd_valid,
  output logic               rd_ready,
  input  logic [DRV_W-1:0]   rd_drv,
  output logic               st_valid,
  input  logic               st_ready,
  output logic [WORD_W-1:0]  st_word
);
  drv_stat_t         stat_arr [NUM_DRV];
  logic              take;
  drv_stat_t         sel_stat;
  logic              sel_unl;
  logic [WORD_W-1:0] fmt_word;

  assign rd_ready = !st_valid || st_ready;
  assign take     = rd_valid && rd_ready;

  for (genvar i = 0; i < NUM_DRV; i++) begin : g_drv
    err_ev_t ev;
    always_comb begin
      ev.eoc = eoc_set[i];
      ev.aer = aer_set[i];
      ev.flg = flg_set[i];
      ev.dte = dte_set[i] | (ovr_pulse && (ovr_drv == DRV_W'(i)));
    end
    dsw_drive_reg u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_set   (ev),
      .busy_set (busy_set[i]),
      .busy_clr (busy_clr[i]),
      .stat_clr (stat_clr[i]),
      .rd_clr   (take && (rd_drv == DRV_W'(i))),
      .stat_q   (stat_arr[i])
    );
  end

  always_comb begin
    sel_stat = '0;
    sel_unl  = 1'b0;
    for (int i = 0; i < NUM_DRV; i++) begin
      if (rd_drv == DRV_W'(i)) begin
        sel_stat = stat_arr[i];
        sel_unl  = unloaded[i];
      end
    end
  end

  dsw_format u_fmt (
    .stat     (sel_stat),
    .unloaded (sel_unl),
    .drv_id   (rd_drv[0]),
    .word     (fmt_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_valid <= 1'b0;
      st_word  <= '0;
    end else if (take) begin
      st_valid <= 1'b1;
      st_word  <= fmt_word;
    end else if (st_ready) begin
      st_valid <= 1'b0;
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=> (st_valid && $stable(st_word)));

  p_any_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> (st_word[B_ANY] == (st_word[B_NRDY] | st_word[B_EOC] | st_word[B_AER]
                                     | st_word[B_FLG] | st_word[B_DTE])));

  p_unloaded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_word[B_NRDY]) |-> (st_word[5:1] == '0));

  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> (st_word[WORD_W-1:8] == '0));
endmodule

// File: tb/disk_status_word_tb.sv
module disk_status_word_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  aer_set = '0, eoc_set = '0, flg_set = '0, dte_set = '0;
  logic [1:0]  busy_set = '0, busy_clr = '0, stat_clr = '0, unloaded = '0;
  logic        ovr_pulse = 1'b0;
  logic [0:0]  ovr_drv = '0;
  logic        rd_valid = 1'b0;
  logic        rd_ready;
  logic [0:0]  rd_drv = '0;
  logic        st_valid;
  logic        st_ready = 1'b0;
  logic [15:0] st_word;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  disk_status_word u_dut (
    .clk(clk), .rst_n(rst_n),
    .aer_set(aer_set), .eoc_set(eoc_set), .flg_set(flg_set), .dte_set(dte_set),
    .busy_set(busy_set), .busy_clr(busy_clr), .stat_clr(stat_clr),
    .ovr_pulse(ovr_pulse), .ovr_drv(ovr_drv), .unloaded(unloaded),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_drv(rd_drv),
    .st_valid(st_valid), .st_ready(st_ready), .st_word(st_word)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  task automatic read_word(input int drv, input string req, input logic [15:0] exp);
    @(negedge clk);
    rd_valid = 1'b1; rd_drv = 1'(drv); st_ready = 1'b0;
    @(negedge clk);
    rd_valid = 1'b0;
    check({req, " valid"}, 16'(st_valid), 16'h1);
    check(req, st_word, exp);
    st_ready = 1'b1;
    @(negedge clk);
    st_ready = 1'b0;
  endtask

  task automatic pulse(ref logic [1:0] sig, input int drv);
    @(negedge clk);
    sig[drv] = 1'b1;
    @(negedge clk);
    sig[drv] = 1'b0;
  endtask

  task automatic t_reset();
    check("R11 st_valid", 16'(st_valid), 16'h0);
    check("R11 rd_ready", 16'(rd_ready), 16'h1);
    read_word(0, "R11 drive0 clean", 16'h0000);
    read_word(1, "R4 drive1 id", 16'h0080);
  endtask

  task automatic t_errors();
    pulse(eoc_set, 0);
    pulse(busy_set, 0);
    read_word(0, "R1 R2 eoc+busy", 16'h0025);
    read_word(0, "R5 busy kept", 16'h0004);
    pulse(flg_set, 1);
    read_word(1, "R1 R4 flagged d1", 16'h0089);
    pulse(busy_set, 1);
    read_word(1, "R2 busy alone", 16'h0084);
    pulse(busy_clr, 1);
    read_word(1, "R10 busy clear", 16'h0080);
    @(negedge clk);
    aer_set[0] = 1'b1; dte_set[1] = 1'b1;
    @(negedge clk);
    aer_set = '0; dte_set = '0;
    read_word(1, "R1 dte d1", 16'h0083);
    read_word(0, "R5 other drive kept", 16'h0015);
  endtask

  task automatic t_unload();
    pulse(eoc_set, 0);
    unloaded[0] = 1'b1;
    read_word(0, "R3 unloaded d0", 16'h0041);
    unloaded[0] = 1'b0;
    read_word(0, "R5 cleared after read", 16'h0004);
    unloaded[1] = 1'b1;
    read_word(1, "R3 unloaded d1", 16'h00C1);
    unloaded[1] = 1'b0;
  endtask

  task automatic t_stat_clr();
    pulse(aer_set, 0);
    pulse(stat_clr, 0);
    read_word(0, "R6 whole clear", 16'h0000);
  endtask

  task automatic t_overrun();
    @(negedge clk);
    ovr_pulse = 1'b1; ovr_drv = 1'b1;
    @(negedge clk);
    ovr_pulse = 1'b0; ovr_drv = 1'b0;
    read_word(1, "R7 overrun d1", 16'h0083);
    read_word(0, "R7 d0 untouched", 16'h0000);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    rd_valid = 1'b1; rd_drv = 1'b0; aer_set[0] = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0; aer_set = '0;
    check("R8 word before set", st_word, 16'h0000);
    st_ready = 1'b1;
    @(negedge clk);
    st_ready = 1'b0;
    read_word(0, "R8 set survives clear", 16'h0011);
    @(negedge clk);
    busy_set[0] = 1'b1; busy_clr[0] = 1'b1;
    @(negedge clk);
    busy_set = '0; busy_clr = '0;
    read_word(0, "R10 set beats clear", 16'h0004);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rd_valid = 1'b1; rd_drv = 1'b1; st_ready = 1'b0;
    @(negedge clk);
    rd_valid = 1'b0;
    check("R9 stalled word", st_word, 16'h0080);
    pulse(flg_set, 1);
    rd_valid = 1'b1; rd_drv = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R9 rd_ready low", 16'(rd_ready), 16'h0);
      check("R9 word held", st_word, 16'h0080);
    end
    st_ready = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
    check("R9 back-to-back valid", 16'(st_valid), 16'h1);
    check("R9 back-to-back word", st_word, 16'h0089);
    @(negedge clk);
    st_ready = 1'b0;
    check("R9 drained", 16'(st_valid), 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_errors();
    t_unload();
    t_stat_clr();
    t_overrun();
    t_same_cycle();
    t_backpressure();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule